// File: doc/BRIEF.md
# Paged Write Cache with Timed Commit Sequencer

This block sits between a serial-bus slave engine and a non-volatile memory array. While a write transaction is running, the engine hands it one byte at a time, each with its full byte address. The block gathers these bytes into a small cache of page lines. Each line holds one aligned page of `PAGE_BYTES` bytes and a per-byte written mask. A byte whose page is already cached merges into that line. A byte for a page not yet cached takes the next free line. When every line is in use, bytes for further new pages are dropped.

When the engine reports the end of the transaction with a commit pulse, the block starts a self-timed programming sequence. It presents each cached page to the array in turn, in the order the pages were first loaded. Each page is shown with its page number, its bytes and its written mask, and it stays on the request interface for exactly `TICKS_PER_PAGE` timebase ticks. The total program time therefore grows with the number of pages loaded. A busy flag stays high for the whole sequence, so that the engine can withhold acknowledges. Writes and commits that arrive while busy is high are ignored.

Top module: `wcache_seq`

## Requirements
- R1: After reset, `busy` and `prog_valid` are low and the cache is empty.
- R2: A byte written to address A is stored in the page `A[ADDR_W-1:OFS_W]` at byte offset `o = A[OFS_W-1:0]`. During programming it appears on `prog_data[8*o+7:8*o]` with `prog_be[o]` set. Offsets never written in that page have their `prog_be` bit at 0.
- R3: Several writes to one cached page merge into a single line. A repeated write to the same byte keeps the last value.
- R4: Each write to a page not yet cached takes a new line, up to `LINES` distinct pages. Once the cache is full, writes to new pages are dropped, and writes to pages already cached are still accepted.
- R5: A commit pulse with at least one line loaded raises `busy` in the next cycle. `busy` stays high until N×`TICKS_PER_PAGE` ticks have been counted, where N is the number of lines loaded. It falls in the cycle after the final tick.
- R6: `prog_valid` equals `busy`. Pages are presented in first-load order, each page stays for exactly `TICKS_PER_PAGE` ticks, and `prog_page` holds steady within that window.
- R7: A commit pulse while the cache is empty starts nothing, and `busy` stays low.
- R8: While `busy` is high, `wr_en` and `commit` have no effect. A write in the same cycle as a commit pulse is ignored. The cache is empty again after a sequence completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Byte value |
| commit | input | 1 | End-of-transaction pulse that starts programming |
| tick | input | 1 | Timebase tick |
| busy | output | 1 | High while the programming sequence runs |
| prog_valid | output | 1 | Page request to the array is valid |
| prog_page | output | ADDR_W-log2(PAGE_BYTES) | Page number being programmed |
| prog_data | output | 8*PAGE_BYTES | Page bytes, byte o at bits 8o+7..8o |
| prog_be | output | PAGE_BYTES | Per-byte written mask |

## Verification
The bench sweeps the number of distinct pages in one transaction from one up to one past the cache capacity. It uses scattered offsets and repeated bytes, then compares every presented page, mask and masked data against an arithmetic model. A design that allocated on a hit would present a page twice. A design that let an overflow page evict a line, or that blocked hits once full, would present the wrong page set. Timing is checked tick by tick: busy must be high before every expected tick and low right after the last one, which catches a program time that does not scale with the page count. Separate cases send a write and a commit while programming is under way, a write together with a commit, and a commit with an empty cache. A design that let any of these through would either start a later sequence or miss one.

// File: rtl/wcache_pkg.sv
package wcache_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic {
      MODE_LOAD = 1'b0,
      MODE_PROG = 1'b1
   } seq_mode_e;

endpackage

// File: rtl/wcache_tags.sv
module wcache_tags #(
   parameter int LINES = 8,
   parameter int TAG_W = 9,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             alloc,
   input  logic [IDX_W-1:0] alloc_idx,
   input  logic             clr,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic [TAG_W-1:0] rd_tag
);

   logic [LINES-1:0] match;
   logic [TAG_W-1:0] tag_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic             vld_q;
      logic [TAG_W-1:0] tag_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            tag_q <= '0;
         end else if (clr) begin
            vld_q <= 1'b0;
         end else if (alloc && alloc_idx == IDX_W'(g)) begin
            vld_q <= 1'b1;
            tag_q <= lk_tag;
         end
      end

      assign match[g]   = vld_q && (tag_q == lk_tag);
      assign tag_arr[g] = tag_q;
   end

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < LINES; i++) begin
         if (match[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit    = |match;
   assign rd_tag = tag_arr[rd_idx];

   // R4
   one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

endmodule

// File: rtl/wcache_lines.sv
module wcache_lines
   import wcache_pkg::*;
#(
   parameter int LINES      = 8,
   parameter int PAGE_BYTES = 8,
   parameter int IDX_W      = 3,
   parameter int OFS_W      = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic                         fresh,
   input  logic [IDX_W-1:0]             w_idx,
   input  logic [OFS_W-1:0]             w_ofs,
   input  logic [BYTE_W-1:0]            w_byte,
   input  logic [IDX_W-1:0]             rd_idx,
   output logic [PAGE_BYTES*BYTE_W-1:0] rd_data,
   output logic [PAGE_BYTES-1:0]        rd_be
);

   localparam int DW = PAGE_BYTES * BYTE_W;

   logic [DW-1:0]         data_arr [LINES];
   logic [PAGE_BYTES-1:0] be_arr   [LINES];
   logic [PAGE_BYTES-1:0] ofs_bit;

   assign ofs_bit = PAGE_BYTES'(1) << w_ofs;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [DW-1:0]         dat_q;
      logic [PAGE_BYTES-1:0] be_q;
      logic                  sel;

      assign sel = we && (w_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (sel) dat_q[BYTE_W*int'(w_ofs) +: BYTE_W] <= w_byte;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)     be_q <= '0;
         else if (sel)   be_q <= fresh ? ofs_bit : (be_q | ofs_bit);
      end

      assign data_arr[g] = dat_q;
      assign be_arr[g]   = be_q;
   end

   assign rd_data = data_arr[rd_idx];
   assign rd_be   = be_arr[rd_idx];

   // R2
   mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we && !fresh && (rd_idx == w_idx) |=> rd_be[$past(w_ofs)]);

endmodule

// File: rtl/wcache_pacer.sv
module wcache_pacer #(
   parameter int TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic done
);

   if (TICKS == 1) begin : g_direct
      assign done = run && tick;
   end else begin : g_count
      localparam int TW = $clog2(TICKS);
      logic [TW-1:0] cnt_q;
      logic          at_end;

      assign at_end = (cnt_q == TW'(TICKS - 1));
      assign done   = run && tick && at_end;

      always_ff @(posedge clk) begin
         if (!rst_n || !run) cnt_q <= '0;
         else if (tick)      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end

      // R5
      cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= TW'(TICKS - 1));
   end

endmodule

// File: rtl/wcache_seq.sv
module wcache_seq
   import wcache_pkg::*;
#(
   parameter int ADDR_W         = 12,
   parameter int PAGE_BYTES     = 8,
   parameter int LINES          = 8,
   parameter int TICKS_PER_PAGE = 1000
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [ADDR_W-1:0]                     wr_addr,
   input  logic [7:0]                            wr_data,
   input  logic                                  commit,
   input  logic                                  tick,
   output logic                                  busy,
   output logic                                  prog_valid,
   output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  prog_page,
   output logic [PAGE_BYTES*8-1:0]               prog_data,
   output logic [PAGE_BYTES-1:0]                 prog_be
);

   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int TAG_W = ADDR_W - OFS_W;
   localparam int IDX_W = $clog2(LINES);
   localparam int CNT_W = $clog2(LINES + 1);

   if (PAGE_BYTES < 2 || (1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width");
   end
   if (TICKS_PER_PAGE < 1) begin : g_bad_ticks
      $error("TICKS_PER_PAGE must be positive");
   end

   seq_mode_e        mode_q;
   logic [CNT_W-1:0] fill_q;
   logic [IDX_W-1:0] cur_q;

   logic             hit;
   logic [IDX_W-1:0] hit_idx;
   logic [IDX_W-1:0] w_idx;
   logic [TAG_W-1:0] cur_tag;
   logic             loading;
   logic             wr_ok;
   logic             room;
   logic             alloc;
   logic             store_we;
   logic             start;
   logic             page_done;
   logic             last_page;

   assign loading   = (mode_q == MODE_LOAD);
   assign wr_ok     = wr_en && loading && !commit;
   assign room      = (fill_q < CNT_W'(LINES));
   assign alloc     = wr_ok && !hit && room;
   assign store_we  = wr_ok && (hit || room);
   assign w_idx     = hit ? hit_idx : fill_q[IDX_W-1:0];
   assign start     = commit && loading && (fill_q != '0);
   assign last_page = page_done && (CNT_W'(cur_q) == fill_q - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_LOAD;
         fill_q <= '0;
         cur_q  <= '0;
      end else if (start) begin
         mode_q <= MODE_PROG;
         cur_q  <= '0;
      end else if (last_page) begin
         mode_q <= MODE_LOAD;
         fill_q <= '0;
         cur_q  <= '0;
      end else if (page_done) begin
         cur_q  <= cur_q + 1'b1;
      end else if (alloc) begin
         fill_q <= fill_q + 1'b1;
      end
   end

   wcache_tags #(
      .LINES (LINES),
      .TAG_W (TAG_W),
      .IDX_W (IDX_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_tag    (wr_addr[ADDR_W-1:OFS_W]),
      .alloc     (alloc),
      .alloc_idx (fill_q[IDX_W-1:0]),
      .clr       (last_page),
      .rd_idx    (cur_q),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .rd_tag    (cur_tag)
   );

   wcache_lines #(
      .LINES      (LINES),
      .PAGE_BYTES (PAGE_BYTES),
      .IDX_W      (IDX_W),
      .OFS_W      (OFS_W)
   ) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (store_we),
      .fresh   (alloc),
      .w_idx   (w_idx),
      .w_ofs   (wr_addr[OFS_W-1:0]),
      .w_byte  (wr_data),
      .rd_idx  (cur_q),
      .rd_data (prog_data),
      .rd_be   (prog_be)
   );

   wcache_pacer #(
      .TICKS (TICKS_PER_PAGE)
   ) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (!loading),
      .tick  (tick),
      .done  (page_done)
   );

   assign busy       = !loading;
   assign prog_valid = !loading;
   assign prog_page  = cur_tag;

   // R4
   fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= CNT_W'(LINES));

   // R6
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !page_done |=> $stable(prog_page));

   // R7
   empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit && loading && (fill_q == '0) |=> !busy);

   // R8
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !last_page |=> $stable(fill_q));

endmodule

// File: tb/sim_wcache_seq.sv
module sim_wcache_seq;

   localparam int AW = 12;
   localparam int NL = 4;
   localparam int NT = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [AW-1:0] wr_addr;
   logic [7:0]  wr_data;
   logic        commit;
   logic        tick;
   logic        busy;
   logic        prog_valid;
   logic [AW-4:0] prog_page;
   logic [63:0] prog_data;
   logic [7:0]  prog_be;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   int          m_n;
   int          m_tag [NL];
   logic [63:0] m_dat [NL];
   logic [7:0]  m_be  [NL];

   always #2 clk = ~clk;

   wcache_seq #(
      .ADDR_W         (AW),
      .PAGE_BYTES     (8),
      .LINES          (NL),
      .TICKS_PER_PAGE (NT)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .commit     (commit),
      .tick       (tick),
      .busy       (busy),
      .prog_valid (prog_valid),
      .prog_page  (prog_page),
      .prog_data  (prog_data),
      .prog_be    (prog_be)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic drive_wr(input int page, input int ofs, input logic [7:0] d);
      wr_en   = 1'b1;
      wr_addr = AW'(page * 8 + ofs);
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wr(input int page, input int ofs, input logic [7:0] d);
      int idx = -1;
      drive_wr(page, ofs, d);
      for (int i = 0; i < m_n; i++) if (m_tag[i] == page) idx = i;
      if (idx < 0 && m_n < NL) begin
         idx = m_n;
         m_tag[idx] = page;
         m_be[idx]  = '0;
         m_n++;
      end
      if (idx >= 0) begin
         m_dat[idx][8*ofs +: 8] = d;
         m_be[idx][ofs] = 1'b1;
      end
   endtask

   task automatic pulse_commit();
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_prog(input bit inject);
      logic [63:0] mask;
      pulse_commit();
      chk("R5 busy after commit", 64'(busy), 64'd1);
      for (int p = 0; p < m_n; p++) begin
         for (int b = 0; b < 8; b++) mask[8*b +: 8] = {8{m_be[p][b]}};
         chk("R6 valid", 64'(prog_valid), 64'd1);
         chk("R6 page order", 64'(prog_page), 64'(m_tag[p]));
         chk("R2 byte mask", 64'(prog_be), 64'(m_be[p]));
         chk("R3 merged data", prog_data & mask, m_dat[p] & mask);
         for (int t = 0; t < NT; t++) begin
            chk("R5 busy before tick", 64'(busy), 64'd1);
            if (inject && p == 0 && t == 1) begin
               drive_wr(300, 4, 8'hEE);
               pulse_commit();
               chk("R8 busy kept", 64'(busy), 64'd1);
            end
            pulse_tick();
         end
      end
      chk("R5 busy released", 64'(busy), 64'd0);
      chk("R6 valid released", 64'(prog_valid), 64'd0);
      m_n = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      commit = 1'b0; tick = 1'b0; m_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 busy reset", 64'(busy), 64'd0);
      chk("R1 valid reset", 64'(prog_valid), 64'd0);

      // R7: empty cache commit
      pulse_commit();
      chk("R7 empty commit", 64'(busy), 64'd0);
      pulse_tick();
      chk("R7 still idle", 64'(busy), 64'd0);

      // R2 R3 R4: sweep page count past capacity
      for (int k = 1; k <= NL + 1; k++) begin
         for (int i = 0; i < k; i++) begin
            int pg = (i * 37 + k * 11 + 5) % 512;
            int first = -1;
            for (int o = 0; o < 8; o++) begin
               if (((o + i + k) % 3) != 0) begin
                  wr(pg, o, 8'((pg * 7 + o * 13 + k) & 255));
                  if (first < 0) first = o;
               end
            end
            wr(pg, first, 8'(((pg * 7 + first * 13 + k) & 255) ^ 8'h5A));
         end
         // hit on the first page after the cache may be full
         wr((k * 11 + 5) % 512, 7, 8'(k * 29));
         run_prog(1'b0);
      end

      // R8: write and commit during programming are ignored
      wr(100, 2, 8'h3C);
      run_prog(1'b1);
      pulse_commit();
      chk("R8 dropped during busy", 64'(busy), 64'd0);

      // R8: write in the same cycle as commit is ignored
      wr_en = 1'b1; wr_addr = AW'(50 * 8 + 1); wr_data = 8'h77; commit = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; commit = 1'b0;
      chk("R8 same cycle commit", 64'(busy), 64'd0);
      pulse_commit();
      chk("R8 same cycle write dropped", 64'(busy), 64'd0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule